// File: doc/BRIEF.md
# Timing-Graded Hebbian Synapse

This block is a single learning connection between one input neuron and one output neuron of a spiking network. It stores an 8-bit weight. In every cycle in which the input (pre-synaptic) neuron spikes, it presents that weight to the downstream soma as a weighted contribution. In all other cycles it presents zero.

Learning runs in frames of a fixed number of cycles, 16 by default. A one-cycle frame-start pulse marks slot 0. The block records the slot of the first pre spike and the slot of the first post (axonal) spike seen in the frame. After the last slot, it sorts the pre-to-post gap into one of four bins and applies that bin's signed step to the weight. The result saturates at 0 and 255 and never wraps.

A close lead earns a large increase, a medium lead a moderate one, and a long lead a small decrease. A pre spike that comes after the post spike costs a large decrease. The weight can be written and read back directly, so that trained values can be saved and restored.

Top module: `hebb_synapse`

## Requirements
- R1: After reset, weight_o equals the parameter WINIT (default 128) and psp_o is 0.
- R2: psp_o equals weight_o in any cycle where pre_spike_i is 1, and is 0 in any cycle where pre_spike_i is 0.
- R3: If wload_i is 1 at a clock edge, weight_o equals wdata_i from the next cycle onward. A load takes precedence over a learning update at the same edge.
- R4: The cycle with frame_start_i high is slot 0, and the frame covers slots 0 to 15. Any learning update becomes visible on weight_o 17 cycles after the frame-start cycle. A new frame_start_i restarts slot counting.
- R5: With gap = post slot minus pre slot, a gap of 0 to 5 raises the weight by STEP_STRONG (default +16).
- R6: A gap of 6 to 10 raises the weight by STEP_MILD (default +8).
- R7: A gap above 10 changes the weight by STEP_WEAK (default -2).
- R8: A pre slot later than the post slot changes the weight by STEP_LATE (default -16).
- R9: The updated weight is clamped to the range 0 to 255.
- R10: The weight is left unchanged if learn_en_i is 0 at the update edge, or if the frame lacked either a pre spike or a post spike.
- R11: Only the first pre spike and the first post spike of a frame are timed. Later spikes of the same kind in that frame do not alter the update.
- R12: Spikes that arrive while no frame is running are not timed and cause no weight change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse that marks slot 0 of a frame |
| pre_spike_i | input | 1 | Spike from the input neuron |
| post_spike_i | input | 1 | Axonal spike from the output neuron |
| learn_en_i | input | 1 | Permits the end-of-frame weight update |
| wload_i | input | 1 | Writes wdata_i into the weight |
| wdata_i | input | 8 | Weight value to load |
| weight_o | output | 8 | Current stored weight |
| psp_o | output | 8 | Weighted value sent to the soma |

## Verification
The assertions rely on frame_start_i arriving no more often than once every 17 cycles. Because of that spacing, the one-cycle end pulse and the update edge never overlap a restart. They also rely on learn_en_i being steady across the update edge. The directed stimulus starts each frame only after the previous update has been observed, and it changes learn_en_i only between frames. Spikes are driven only inside frames, except in the scenario that deliberately drives them with no frame running.

// File: rtl/hebb_syn_pkg.sv
package hebb_syn_pkg;
  typedef enum logic [1:0] {
    BIN_STRONG = 2'd0,
    BIN_MILD   = 2'd1,
    BIN_WEAK   = 2'd2,
    BIN_LATE   = 2'd3
  } gap_bin_e;
endpackage

// File: rtl/syn_frame_timer.sv
module syn_frame_timer #(
  parameter int FRAME_LEN = 16,
  localparam int SW = $clog2(FRAME_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  output logic [SW-1:0] slot_o,
  output logic          in_frame_o,
  output logic          frame_end_o
);
  logic [SW-1:0] slot_q, cur_slot;
  logic          act_q, end_q, last;

  assign cur_slot   = frame_start_i ? '0 : slot_q + 1'b1;
  assign in_frame_o = frame_start_i | act_q;
  assign last       = (cur_slot == SW'(FRAME_LEN - 1));
  assign slot_o     = cur_slot;
  assign frame_end_o = end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      act_q  <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      end_q <= in_frame_o & last;
      if (in_frame_o) begin
        slot_q <= cur_slot;
        act_q  <= !last;
      end else begin
        act_q <= 1'b0;
      end
    end
  end

  p_end_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |=> !end_q);
  p_end_after_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_o && last) |=> end_q);
endmodule

// File: rtl/syn_spike_stamp.sv
module syn_spike_stamp #(
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          in_frame_i,
  input  logic [SW-1:0] slot_i,
  input  logic          spike_i,
  output logic          seen_o,
  output logic [SW-1:0] stamp_o
);
  logic          seen_q, hit;
  logic [SW-1:0] stamp_q;

  // first spike of the frame only; a restart re-arms
  assign hit = in_frame_i & spike_i & (clear_i | !seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      stamp_q <= '0;
    end else if (hit) begin
      seen_q  <= 1'b1;
      stamp_q <= slot_i;
    end else if (clear_i) begin
      seen_q  <= 1'b0;
    end
  end

  assign seen_o  = seen_q;
  assign stamp_o = stamp_q;

  p_first_kept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !clear_i) |=> (seen_q && $stable(stamp_q)));
  p_no_stamp_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_frame_i && !seen_q) |=> !seen_q);
endmodule

// File: rtl/syn_gap_bin.sv
module syn_gap_bin
  import hebb_syn_pkg::*;
#(
  parameter int SW         = 4,
  parameter int STRONG_MAX = 5,
  parameter int MILD_MAX   = 10
) (
  input  logic [SW-1:0] pre_t_i,
  input  logic [SW-1:0] post_t_i,
  output gap_bin_e      bin_o
);
  logic [SW-1:0] gap;
  assign gap = post_t_i - pre_t_i;

  always_comb begin
    if (pre_t_i > post_t_i)                bin_o = BIN_LATE;
    else if (int'(gap) <= STRONG_MAX)      bin_o = BIN_STRONG;
    else if (int'(gap) <= MILD_MAX)        bin_o = BIN_MILD;
    else                                   bin_o = BIN_WEAK;
  end
endmodule

// File: rtl/syn_weight_reg.sv
module syn_weight_reg #(
  parameter int          WW    = 8,
  parameter logic [WW-1:0] WINIT = 8'd128,
  localparam int         SUMW  = WW + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [WW-1:0]          ldata_i,
  input  logic                   apply_i,
  input  logic signed [SUMW-1:0] step_i,
  output logic [WW-1:0]          w_o
);
  localparam logic signed [SUMW-1:0] WMAX = SUMW'((1 << WW) - 1);
  logic [WW-1:0]          w_q, w_upd;
  logic signed [SUMW-1:0] sum;

  assign sum = $signed({2'b00, w_q}) + step_i;

  always_comb begin
    if (sum < 0)         w_upd = '0;
    else if (sum > WMAX) w_upd = '1;
    else                 w_upd = sum[WW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      w_q <= WINIT;
    else if (load_i)  w_q <= ldata_i;
    else if (apply_i) w_q <= w_upd;
  end

  assign w_o = w_q;

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (w_q == $past(ldata_i)));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !apply_i) |=> $stable(w_q));
  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && !load_i && !step_i[SUMW-1]) |=> (w_q >= $past(w_q)));
  p_no_underflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && !load_i && step_i[SUMW-1]) |=> (w_q <= $past(w_q)));
endmodule

// File: rtl/hebb_synapse.sv
module hebb_synapse
  import hebb_syn_pkg::*;
#(
  parameter int FRAME_LEN   = 16,
  parameter int WW          = 8,
  parameter logic [WW-1:0] WINIT = 8'd128,
  parameter int STRONG_MAX  = 5,
  parameter int MILD_MAX    = 10,
  parameter int STEP_STRONG = 16,
  parameter int STEP_MILD   = 8,
  parameter int STEP_WEAK   = -2,
  parameter int STEP_LATE   = -16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          pre_spike_i,
  input  logic          post_spike_i,
  input  logic          learn_en_i,
  input  logic          wload_i,
  input  logic [WW-1:0] wdata_i,
  output logic [WW-1:0] weight_o,
  output logic [WW-1:0] psp_o
);
  localparam int SW   = $clog2(FRAME_LEN);
  localparam int SUMW = WW + 2;

  logic [SW-1:0]          slot;
  logic                   in_frame, frame_end, apply;
  logic [1:0]             seen;
  logic [SW-1:0]          stamp [2];
  logic [1:0]             spikes;
  gap_bin_e               bin;
  logic signed [SUMW-1:0] step;

  assign spikes = {post_spike_i, pre_spike_i};

  syn_frame_timer #(.FRAME_LEN(FRAME_LEN)) i_timer (
    .clk_i, .rst_ni, .frame_start_i,
    .slot_o(slot), .in_frame_o(in_frame), .frame_end_o(frame_end)
  );

  // index 0: pre, index 1: post
  for (genvar g = 0; g < 2; g++) begin : g_stamp
    syn_spike_stamp #(.SW(SW)) i_stamp (
      .clk_i, .rst_ni,
      .clear_i(frame_start_i), .in_frame_i(in_frame), .slot_i(slot),
      .spike_i(spikes[g]), .seen_o(seen[g]), .stamp_o(stamp[g])
    );
  end

  syn_gap_bin #(.SW(SW), .STRONG_MAX(STRONG_MAX), .MILD_MAX(MILD_MAX)) i_bin (
    .pre_t_i(stamp[0]), .post_t_i(stamp[1]), .bin_o(bin)
  );

  always_comb begin
    unique case (bin)
      BIN_STRONG: step = SUMW'(STEP_STRONG);
      BIN_MILD:   step = SUMW'(STEP_MILD);
      BIN_WEAK:   step = SUMW'(STEP_WEAK);
      default:    step = SUMW'(STEP_LATE);
    endcase
  end

  assign apply = frame_end & learn_en_i & (&seen);

  syn_weight_reg #(.WW(WW), .WINIT(WINIT)) i_wreg (
    .clk_i, .rst_ni,
    .load_i(wload_i), .ldata_i(wdata_i),
    .apply_i(apply), .step_i(step), .w_o(weight_o)
  );

  assign psp_o = pre_spike_i ? weight_o : '0;

  p_psp_pre_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_spike_i && !wload_i && !apply) |=> $stable(weight_o));
  p_no_learn_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!learn_en_i && !wload_i) |=> $stable(weight_o));
endmodule

// File: tb/test_hebb_synapse.sv
module test_hebb_synapse;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs = 1'b0, pre = 1'b0, post = 1'b0, learn = 1'b0, wload = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] weight, psp;
  int checks = 0, errors = 0;
  int w_exp = 128;

  always #(CLK_PERIOD/2) clk = ~clk;

  hebb_synapse i_hebb_synapse (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .pre_spike_i(pre),
    .post_spike_i(post), .learn_en_i(learn), .wload_i(wload), .wdata_i(wdata),
    .weight_o(weight), .psp_o(psp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_bit(input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int model(input int w, input int p, input int q);
    int d, r;
    d = q - p;
    if (p > q)        r = w - 16;
    else if (d <= 5)  r = w + 16;
    else if (d <= 10) r = w + 8;
    else              r = w - 2;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic load_w(input int v);
    @(negedge clk); wload = 1'b1; wdata = 8'(v);
    @(negedge clk); wload = 1'b0;
    w_exp = v;
    chk(weight == 8'(v), "R3 load", weight, v);
  endtask

  task automatic run_frame(input logic [15:0] pm, input logic [15:0] qm,
                           input bit ln, input bit ld_end, input int ld_val,
                           input string req);
    int p, q;
    p = first_bit(pm);
    q = first_bit(qm);
    learn = ln;
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      fs = (s == 0); pre = pm[s]; post = qm[s];
      #1;
      chk(psp == (pm[s] ? 8'(w_exp) : 8'd0), "R2 psp", psp, pm[s] ? w_exp : 0);
    end
    @(negedge clk);
    fs = 1'b0; pre = 1'b0; post = 1'b0;
    if (ld_end) begin wload = 1'b1; wdata = 8'(ld_val); end
    @(negedge clk);
    wload = 1'b0;
    if (ld_end) w_exp = ld_val;
    else if (ln && p >= 0 && q >= 0) w_exp = model(w_exp, p, q);
    chk(weight == 8'(w_exp), req, weight, w_exp);
    learn = 1'b0;
  endtask

  task automatic t_reset;
    chk(weight == 8'd128, "R1 reset weight", weight, 128);
    chk(psp == 8'd0, "R1 reset psp", psp, 0);
  endtask

  task automatic t_bins;
    load_w(100);
    run_frame(16'h0008, 16'h0100, 1, 0, 0, "R5 gap 5");
    run_frame(16'h0004, 16'h0004, 1, 0, 0, "R5 gap 0");
    run_frame(16'h0001, 16'h0040, 1, 0, 0, "R6 gap 6");
    run_frame(16'h0002, 16'h0800, 1, 0, 0, "R6 gap 10");
    run_frame(16'h0001, 16'h0800, 1, 0, 0, "R7 gap 11");
    run_frame(16'h0001, 16'h8000, 1, 0, 0, "R7 gap 15");
    run_frame(16'h0020, 16'h0010, 1, 0, 0, "R8 pre one after post");
    run_frame(16'h8000, 16'h0001, 1, 0, 0, "R8 pre last");
  endtask

  task automatic t_saturate;
    load_w(250);
    run_frame(16'h0002, 16'h0004, 1, 0, 0, "R9 clamp high");
    chk(weight == 8'd255, "R9 top", weight, 255);
    load_w(5);
    run_frame(16'h0200, 16'h0004, 1, 0, 0, "R9 clamp low");
    chk(weight == 8'd0, "R9 bottom", weight, 0);
  endtask

  task automatic t_no_update;
    load_w(77);
    run_frame(16'h0002, 16'h0004, 0, 0, 0, "R10 learn off");
    run_frame(16'h0002, 16'h0000, 1, 0, 0, "R10 no post");
    run_frame(16'h0000, 16'h0004, 1, 0, 0, "R10 no pre");
  endtask

  task automatic t_first_only;
    load_w(60);
    // first pre at 1, post at 13 -> gap 12 (weak); later pre at 12 ignored
    run_frame(16'h1002, 16'h2000, 1, 0, 0, "R11 later pre ignored");
    // first post at 2, pre at 4 -> late; later post at 9 ignored
    run_frame(16'h0010, 16'h0204, 1, 0, 0, "R11 later post ignored");
  endtask

  task automatic t_load_wins;
    load_w(40);
    run_frame(16'h0001, 16'h0002, 1, 1, 200, "R3 load over update");
  endtask

  task automatic t_timing;
    load_w(30);
    learn = 1'b1;
    @(negedge clk); fs = 1'b1; pre = 1'b1; post = 1'b1;
    @(negedge clk); fs = 1'b0; pre = 1'b0; post = 1'b0;
    for (int i = 0; i < 15; i++) @(negedge clk);
    chk(weight == 8'd30, "R4 not yet at cycle 16", weight, 30);
    @(negedge clk);
    chk(weight == 8'd46, "R4 update at cycle 17", weight, 46);
    learn = 1'b0;
    w_exp = 46;
  endtask

  task automatic t_idle_spikes;
    load_w(90);
    learn = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); pre = (i % 3 == 0); post = (i % 5 == 1);
    end
    @(negedge clk); pre = 1'b0; post = 1'b0;
    @(negedge clk);
    chk(weight == 8'd90, "R12 idle spikes", weight, 90);
    // a frame without spikes must not pick up the idle ones
    run_frame(16'h0000, 16'h0000, 1, 0, 0, "R12 no stale stamps");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_bins();
    t_saturate();
    t_no_update();
    t_first_only();
    t_load_wins();
    t_timing();
    t_idle_spikes();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule